// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds the pending inter-processor interrupt (IPI) and timer interrupt state for up to four processors and drives one IPI line and one timer line per processor. Software reaches it through a 64-bit register port with a 2-bit register select. Any processor may post or clear IPIs for any set of processors. A periodic tick input marks a timer interrupt pending on every processor, and software acknowledges each processor's timer interrupt on its own.

A single write to the shared control register can post IPIs, clear IPIs and clear timer interrupts together, each through its own 4-bit processor-mask field. The dedicated registers do one of these operations per write, with the mask in the low bits. A post to a processor that already has an IPI pending, and a clear of an IPI that is not pending, change nothing and produce a one-cycle warning pulse. A write that names nothing produces a one-cycle error pulse. Reads are combinational, and the requester-ID input is folded into control-register reads.

Top module: `ipi_tmr_ctrl_top`

## Requirements
- R1: After reset, ipiIrq, timerIrq, warnPulse and errPulse are all 0.
- R2: A write to the control register (regAddr 0) posts IPIs for the processors set in data bits 15:12 and clears IPIs for those set in bits 11:8. When one processor is named in both fields, its IPI ends cleared. ipiIrq shows the result one cycle after the write edge.
- R3: A control-register write clears the timer interrupts of the processors set in data bits 7:4.
- R4: Each dedicated register acts on the mask in data bits 3:0. A write to regAddr 1 posts IPIs, a write to regAddr 2 clears IPIs, and a write to regAddr 3 clears timer interrupts.
- R5: A cycle with timerTick high sets every processor's timer-pending bit. If a timer clear falls in the same cycle, the tick wins and all timer bits end set.
- R6: warnPulse is high for exactly the one cycle after a write that posts an IPI already pending or clears an IPI that is neither pending nor posted by the same write. Those duplicate or missing bits keep their state.
- R7: errPulse is high for the one cycle after an invalid write, and that write changes no state. A write is invalid if it goes to the control register with data bits 15:4 all zero and bit 28 clear, or to a dedicated register with data bits 3:0 all zero. A control write carrying only bit 28 is accepted, changes nothing and raises no error.
- R8: While regRdEn is high, regRdData depends on regAddr, and every bit not listed below is 0. regAddr 2 returns the IPI pending mask in bits 3:0, and regAddr 3 returns the timer pending mask in bits 3:0. regAddr 1 returns 0. regAddr 0 returns the IPI mask in bits 11:8, the timer mask in bits 7:4 and reqId in bits 1:0. While regRdEn is low, regRdData is 0.
- R9: ipiIrq and timerIrq hold the pending masks, and warnPulse and errPulse stay low when there is no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read enable |
| regAddr | input | 2 | Register select: 0 control, 1 IPI request, 2 IPI status, 3 timer status |
| regWrData | input | 64 | Write data |
| reqId | input | 2 | ID of the processor making the read |
| timerTick | input | 1 | Periodic timer tick, one cycle wide |
| regRdData | output | 64 | Read data, combinational |
| ipiIrq | output | 4 | Per-processor IPI lines |
| timerIrq | output | 4 | Per-processor timer interrupt lines |
| warnPulse | output | 1 | Duplicate post or clear of a non-pending IPI |
| errPulse | output | 1 | Invalid write |

## Verification
A timer tick and a timer clear can land in the same cycle, and an IPI post and an IPI clear can also coincide, either inside one control write or when the same processor is named in both fields. Random stimulus drives timerTick on roughly half the cycles together with random control and dedicated writes. Directed cases place a tick on a control write that clears all timer bits, and put the same processor in both IPI fields. The bench model judges each outcome by its stated rule: the tick wins, post-then-clear ends cleared, and no warning is raised for a bit that the same write posts and clears.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
  localparam int MASK_W = 4;
  localparam int DATA_W = 64;
  localparam int POST_LSB = 12;
  localparam int IPI_CLR_LSB = 8;
  localparam int TIM_CLR_LSB = 4;
  localparam int ERR_ACK_BIT = 28;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_IPI_REQ = 2'd1,
    REG_IPI_ST  = 2'd2,
    REG_TIM_ST  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [MASK_W-1:0] postIpi;
    logic [MASK_W-1:0] clrIpi;
    logic [MASK_W-1:0] clrTim;
    logic              badWrite;
  } strobes_t;
endpackage

// File: rtl/ipi_tmr_ctrl.sv
module ipi_tmr_ctrl
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output strobes_t          stb
);
  localparam logic [MASK_W-1:0] CPU_EN = MASK_W'((1 << NUM_CPU) - 1);

  logic [MASK_W-1:0] fPost, fIpiClr, fTimClr, fLow;
  logic              fAck;

  assign fPost   = regWrData[POST_LSB +: MASK_W];
  assign fIpiClr = regWrData[IPI_CLR_LSB +: MASK_W];
  assign fTimClr = regWrData[TIM_CLR_LSB +: MASK_W];
  assign fLow    = regWrData[MASK_W-1:0];
  assign fAck    = regWrData[ERR_ACK_BIT];

  always_comb begin
    stb = '0;
    if (regWrEn) begin
      unique case (regSel_e'(regAddr))
        REG_CTRL: begin
          if (fPost == '0 && fIpiClr == '0 && fTimClr == '0 && !fAck) begin
            stb.badWrite = 1'b1;
          end else begin
            stb.postIpi = fPost & CPU_EN;
            stb.clrIpi  = fIpiClr & CPU_EN;
            stb.clrTim  = fTimClr & CPU_EN;
          end
        end
        REG_IPI_REQ: begin
          if (fLow == '0) stb.badWrite = 1'b1;
          else            stb.postIpi = fLow & CPU_EN;
        end
        REG_IPI_ST: begin
          if (fLow == '0) stb.badWrite = 1'b1;
          else            stb.clrIpi = fLow & CPU_EN;
        end
        default: begin
          if (fLow == '0) stb.badWrite = 1'b1;
          else            stb.clrTim = fLow & CPU_EN;
        end
      endcase
    end
  end

  // R7: a zero mask on a dedicated register is always flagged
  assert_zero_mask_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != 2'd0 && regWrData[3:0] == 4'd0) |-> stb.badWrite);

  // R7: an invalid write carries no operation
  assert_bad_is_inert_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.badWrite |-> (stb.postIpi == '0 && stb.clrIpi == '0 && stb.clrTim == '0));
endmodule

// File: rtl/ipi_tmr_dp.sv
module ipi_tmr_dp
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              timerTick,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [1:0]        reqId,
  output logic [DATA_W-1:0] rdData,
  output logic [MASK_W-1:0] ipiPend,
  output logic [MASK_W-1:0] timPend,
  output logic              warnPulse,
  output logic              errPulse
);
  localparam logic [MASK_W-1:0] CPU_EN = MASK_W'((1 << NUM_CPU) - 1);

  logic [MASK_W-1:0] dupPost, missClr, ipiNext, timNext;

  assign dupPost = stb.postIpi & ipiPend;
  assign missClr = stb.clrIpi & ~(ipiPend | stb.postIpi);
  assign ipiNext = (ipiPend | stb.postIpi) & ~stb.clrIpi;
  assign timNext = timerTick ? CPU_EN : (timPend & ~stb.clrTim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ipiPend   <= '0;
      timPend   <= '0;
      warnPulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      ipiPend   <= ipiNext;
      timPend   <= timNext;
      warnPulse <= |(dupPost | missClr);
      errPulse  <= stb.badWrite;
    end
  end

  always_comb begin
    rdData = '0;
    if (regRdEn) begin
      unique case (regSel_e'(regAddr))
        REG_CTRL: begin
          rdData[IPI_CLR_LSB +: MASK_W] = ipiPend;
          rdData[TIM_CLR_LSB +: MASK_W] = timPend;
          rdData[1:0]                   = reqId;
        end
        REG_IPI_ST: rdData[MASK_W-1:0] = ipiPend;
        REG_TIM_ST: rdData[MASK_W-1:0] = timPend;
        default:    rdData = '0;
      endcase
    end
  end

  // R5: a tick leaves every timer bit set, whatever clear came with it
  assert_tick_fills_R5: assert property (@(posedge clk) disable iff (!rstN)
    timerTick |=> (timPend == CPU_EN));

  // R2: a post without a clear leaves the posted bits pending
  assert_post_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.postIpi != '0 && stb.clrIpi == '0) |=>
      ((ipiPend & $past(stb.postIpi)) == $past(stb.postIpi)));

  // R3: a timer clear without a tick empties the named bits
  assert_tim_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!timerTick && stb.clrTim != '0) |=> ((timPend & $past(stb.clrTim)) == '0));

  // R9: no IPI operation keeps the IPI state
  assert_ipi_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.postIpi == '0 && stb.clrIpi == '0) |=> $stable(ipiPend));

  // R6: a duplicate post is always reported
  assert_dup_warn_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.postIpi & ipiPend) != '0) |=> warnPulse);
endmodule

// File: rtl/ipi_tmr_ctrl_top.sv
module ipi_tmr_ctrl_top
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [63:0] regWrData,
  input  logic [1:0]  reqId,
  input  logic        timerTick,
  output logic [63:0] regRdData,
  output logic [3:0]  ipiIrq,
  output logic [3:0]  timerIrq,
  output logic        warnPulse,
  output logic        errPulse
);
  strobes_t stb;

  ipi_tmr_ctrl #(.NUM_CPU(NUM_CPU)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .stb       (stb)
  );

  ipi_tmr_dp #(.NUM_CPU(NUM_CPU)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .timerTick (timerTick),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .reqId     (reqId),
    .rdData    (regRdData),
    .ipiPend   (ipiIrq),
    .timPend   (timerIrq),
    .warnPulse (warnPulse),
    .errPulse  (errPulse)
  );
endmodule

// File: tb/ipi_tmr_ctrl_top_test.sv
module ipi_tmr_ctrl_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [63:0] regWrData = '0;
  logic [1:0]  reqId = 2'd0;
  logic        timerTick = 1'b0;
  logic [63:0] regRdData;
  logic [3:0]  ipiIrq, timerIrq;
  logic        warnPulse, errPulse;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [3:0] mIpi = 4'h0;
  logic [3:0] mTim = 4'h0;

  always #4 clk = ~clk;

  ipi_tmr_ctrl_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .reqId(reqId),
    .timerTick(timerTick), .regRdData(regRdData), .ipiIrq(ipiIrq),
    .timerIrq(timerIrq), .warnPulse(warnPulse), .errPulse(errPulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expBad(input logic [1:0] a, input logic [63:0] d);
    if (a == 2'd0) return (d[15:4] == 12'd0) && !d[28];
    return d[3:0] == 4'd0;
  endfunction

  // Applies one write/tick cycle; starts and ends at a falling edge.
  task automatic step(input logic wr, input logic [1:0] a, input logic [63:0] d,
                      input logic tk, input string req);
    logic [3:0] post, ci, ct, nI, nT;
    logic bad, w;
    post = 4'h0; ci = 4'h0; ct = 4'h0;
    bad = wr && expBad(a, d);
    if (wr && !bad) begin
      case (a)
        2'd0: begin post = d[15:12]; ci = d[11:8]; ct = d[7:4]; end
        2'd1: post = d[3:0];
        2'd2: ci = d[3:0];
        default: ct = d[3:0];
      endcase
    end
    w  = |((post & mIpi) | (ci & ~(mIpi | post)));
    nI = (mIpi | post) & ~ci;
    nT = tk ? 4'hF : (mTim & ~ct);
    regWrEn = wr; regAddr = a; regWrData = d; timerTick = tk;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; timerTick = 1'b0; regWrData = '0;
    mIpi = nI; mTim = nT;
    check({req, " ipiIrq"}, 64'(ipiIrq), 64'(mIpi));
    check({req, " timerIrq"}, 64'(timerIrq), 64'(mTim));
    check({req, " warnPulse R6"}, 64'(warnPulse), 64'(w));
    check({req, " errPulse R7"}, 64'(errPulse), 64'(bad));
  endtask

  task automatic readChk(input logic [1:0] a, input logic [1:0] id);
    logic [63:0] e;
    e = '0;
    case (a)
      2'd0: begin e[11:8] = mIpi; e[7:4] = mTim; e[1:0] = id; end
      2'd2: e[3:0] = mIpi;
      2'd3: e[3:0] = mTim;
      default: e = '0;
    endcase
    regRdEn = 1'b1; regAddr = a; reqId = id;
    #1;
    check("R8 read", regRdData, e);
    regRdEn = 1'b0;
    #1;
    check("R8 idle read zero", regRdData, 64'd0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check("R1 ipiIrq", 64'(ipiIrq), 64'd0);
    check("R1 timerIrq", 64'(timerIrq), 64'd0);
    check("R1 warn/err", 64'({warnPulse, errPulse}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corners
    step(1'b0, 2'd0, 64'd0, 1'b0, "R9 idle");
    step(1'b1, 2'd1, 64'h5, 1'b0, "R4 request");
    step(1'b1, 2'd1, 64'h1, 1'b0, "R6 dup post");
    step(1'b1, 2'd2, 64'h2, 1'b0, "R6 miss clear");
    step(1'b1, 2'd0, 64'h0000_3300, 1'b0, "R2 post+clear same cpu");
    step(1'b0, 2'd0, 64'd0, 1'b1, "R5 tick");
    step(1'b1, 2'd0, 64'h0000_00F0, 1'b1, "R5 tick beats clear");
    step(1'b1, 2'd0, 64'h0000_0050, 1'b0, "R3 timer clear");
    step(1'b1, 2'd3, 64'h2, 1'b0, "R4 timer status clear");
    step(1'b1, 2'd0, 64'h1000_0000, 1'b0, "R7 ack only");
    step(1'b1, 2'd0, 64'hFFFF_0000_0000_000F, 1'b0, "R7 empty ctrl");
    step(1'b1, 2'd1, 64'hF0, 1'b0, "R7 zero request");
    step(1'b1, 2'd3, 64'h0, 1'b0, "R7 zero timer clear");
    for (int a = 0; a < 4; a++) readChk(2'(a), 2'(3 - a));

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] d;
      logic [1:0] a;
      logic wr, tk;
      d = {$urandom, $urandom};
      a = 2'($urandom_range(0, 3));
      wr = ($urandom_range(0, 3) != 0);
      tk = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 7) == 0) d[15:0] = 16'h0;
      if ($urandom_range(0, 3) == 0) d[28] = 1'b0;
      if (a != 2'd0 && $urandom_range(0, 7) == 0) d[3:0] = 4'h0;
      step(wr, a, d, tk, "R2 R3 R4 R5 random");
      if (i % 8 == 0) readChk(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule